// File: doc/BRIEF.md
# Password Access Level Controller

This block decides which of three access levels a host currently holds: user, level 1 or level 2. The host writes a 32-bit password entry one byte at a time over a simple register bus (address, write data, write strobe, read strobe, read data). After every byte write, the full 32-bit entry is compared against two stored passwords. A match with the level 2 password grants level 2. Otherwise, a match with the level 1 password grants level 1. Otherwise, the host stays at user level.

The current level drives two 4-bit masks, one of read enables and one of write enables. Each bit of a mask gates one region of the downstream memory:

- region 0 is identity,
- region 1 is monitoring,
- region 2 is customer data,
- region 3 is settings.

The level 1 password sits in registers that the same bus can rewrite, but only while level 2 is held. The level 2 password is a register loaded from a parameter at reset. The entry itself cannot be read back.

Top module: `pwd_gate`

## Requirements
- R1: After reset, the entry holds FFFFFFFFh and, with both stored passwords at their default of zero, `lvl` is 0 (user).
- R2: A write to address 7Bh, 7Ch, 7Dh or 7Eh replaces bits 31:24, 23:16, 15:8 or 7:0 of the entry, respectively. The level reflects the new entry from the first clock edge after the write.
- R3: When the entry equals the level 1 password and not the level 2 password, `lvl` is 1.
- R4: When the entry equals the level 2 password, `lvl` is 2, even if the entry also equals the level 1 password.
- R5: The level changes only after a bus write. Rewriting an entry byte with the value it already holds leaves the level unchanged.
- R6: Writes to D3h..D6h (bits 31:24 down to 7:0 of the level 1 password) take effect only when `lvl` is 2 at the write edge. At any other level they are ignored.
- R7: A read of any entry address (7Bh..7Eh) returns FFh.
- R8: A read of D3h..D6h returns the matching level 1 password byte while `lvl` is 2, and 00h otherwise. A read of any address the block does not own returns 00h, and so does the read data whenever the read strobe is low.
- R9: `lvl` is encoded as 0 for user, 1 for level 1 and 2 for level 2. The masks for each level are:

  | Level | `rd_ok` | `wr_ok` |
  |---|---|---|
  | user | 0011b | 0000b |
  | level 1 | 0111b | 0100b |
  | level 2 | 1111b | 1111b |

- R10: When the level 1 password resets to all ones, level 1 is granted straight out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data (combinational) |
| lvl | output | 2 | Current access level |
| rd_ok | output | 4 | Per-region read enables |
| wr_ok | output | 4 | Per-region write enables |

## Verification
The comparison is tried with four kinds of entry:

- the reset value of all ones, which separates the power-up state from a real grant;
- an all-zero entry while both passwords are zero, which shows that level 2 wins a double match;
- a changed level 1 password entered byte by byte, which shows that each byte lands in its own position;
- a single-byte mismatch, which shows that access is dropped.

Random writes spread over the entry, the level 1 password and unrelated addresses check that locked password writes are ignored and that the level moves only on a write. A second instance, with an all-ones level 1 password, shows a grant taken directly out of reset.

// File: rtl/pwd_gate.sv
module pwd_gate #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NB = 4,
  parameter logic [AW-1:0] ENTRY_BASE = 8'h7B,
  parameter logic [AW-1:0] PW1_BASE = 8'hD3,
  parameter logic [NB*DW-1:0] L1_INIT = '0,
  parameter logic [NB*DW-1:0] L2_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic [1:0]    lvl,
  output logic [3:0]    rd_ok,
  output logic [3:0]    wr_ok
);
  localparam int PW = NB * DW;

  logic [PW-1:0] entry, pw1, pw2;
  logic [AW-1:0] ent_off, pw_off;
  logic          in_ent, in_pw;

  assign ent_off = bus_addr - ENTRY_BASE;
  assign pw_off  = bus_addr - PW1_BASE;
  assign in_ent  = ent_off < AW'(NB);
  assign in_pw   = pw_off < AW'(NB);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) entry[b*DW +: DW] <= '1;
      else if (bus_we && in_ent && ent_off == AW'(NB-1-b)) entry[b*DW +: DW] <= bus_wdata;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) pw1[b*DW +: DW] <= L1_INIT[b*DW +: DW];
      else if (bus_we && in_pw && pw_off == AW'(NB-1-b) && lvl == 2'd2)
        pw1[b*DW +: DW] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pw2 <= L2_INIT;
  end

  assign lvl = (entry == pw2) ? 2'd2 : (entry == pw1) ? 2'd1 : 2'd0;

  assign rd_ok = (lvl == 2'd2) ? 4'b1111 : (lvl == 2'd1) ? 4'b0111 : 4'b0011;
  assign wr_ok = (lvl == 2'd2) ? 4'b1111 : (lvl == 2'd1) ? 4'b0100 : 4'b0000;

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (in_ent) bus_rdata = '1;
      else if (in_pw && lvl == 2'd2)
        for (int b = 0; b < NB; b++)
          if (pw_off == AW'(NB-1-b)) bus_rdata = pw1[b*DW +: DW];
    end
  end
endmodule

// File: rtl/pwd_gate_chk.sv
module pwd_gate_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NB = 4,
  parameter logic [AW-1:0] ENTRY_BASE = 8'h7B,
  parameter logic [AW-1:0] PW1_BASE = 8'hD3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic          bus_re,
  input logic [DW-1:0] bus_rdata,
  input logic [1:0]    lvl,
  input logic [3:0]    rd_ok,
  input logic [3:0]    wr_ok,
  input logic [NB*DW-1:0] pw1
);
  logic [AW-1:0] e_off, p_off;
  assign e_off = bus_addr - ENTRY_BASE;
  assign p_off = bus_addr - PW1_BASE;

  p_lvl_code_r9: assert property (@(posedge clk) disable iff (!rst_n) lvl != 2'd3);
  p_wr_in_rd_r9: assert property (@(posedge clk) disable iff (!rst_n) (wr_ok & ~rd_ok) == 4'b0000);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n) !bus_we |=> $stable(lvl));
  p_entry_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && e_off < AW'(NB)) |-> bus_rdata == '1);
  p_pw1_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && p_off < AW'(NB) && lvl != 2'd2) |=> $stable(pw1));
  p_idle_read_r8: assert property (@(posedge clk) disable iff (!rst_n) !bus_re |-> bus_rdata == '0);
endmodule

bind pwd_gate pwd_gate_chk #(.AW(AW), .DW(DW), .NB(NB), .ENTRY_BASE(ENTRY_BASE), .PW1_BASE(PW1_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .lvl(lvl), .rd_ok(rd_ok), .wr_ok(wr_ok), .pw1(pw1)
);

// File: tb/sim_pwd_gate.sv
`timescale 1ns/1ps
module sim_pwd_gate;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, rdata, rdata1;
  logic we = 0, re = 0;
  logic [1:0] lvl, lvl1;
  logic [3:0] rd_ok, wr_ok, rd_ok1, wr_ok1;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_entry, m_pw1;

  always #2.5 clk = ~clk;

  pwd_gate u0 (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_re(re), .bus_rdata(rdata), .lvl(lvl), .rd_ok(rd_ok), .wr_ok(wr_ok));
  pwd_gate #(.L1_INIT(32'hFFFF_FFFF)) u1 (.clk(clk), .rst_n(rst_n), .bus_addr(8'h00),
    .bus_wdata(8'h00), .bus_we(1'b0), .bus_re(1'b0), .bus_rdata(rdata1), .lvl(lvl1),
    .rd_ok(rd_ok1), .wr_ok(wr_ok1));

  function automatic logic [1:0] e_lvl();
    return (m_entry == 32'h0) ? 2'd2 : (m_entry == m_pw1) ? 2'd1 : 2'd0;
  endfunction
  function automatic logic [3:0] e_rd(logic [1:0] l);
    return l == 2 ? 4'b1111 : l == 1 ? 4'b0111 : 4'b0011;
  endfunction
  function automatic logic [3:0] e_wr(logic [1:0] l);
    return l == 2 ? 4'b1111 : l == 1 ? 4'b0100 : 4'b0000;
  endfunction
  function automatic logic [7:0] e_read(logic [7:0] a);
    if (a >= 8'h7B && a <= 8'h7E) return 8'hFF;
    if (a >= 8'hD3 && a <= 8'hD6 && e_lvl() == 2) return m_pw1[(3-(a-8'hD3))*8 +: 8];
    return 8'h00;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic check_lvl(string req);
    chk(lvl == e_lvl(), req, lvl, e_lvl());
    chk(rd_ok == e_rd(e_lvl()) && wr_ok == e_wr(e_lvl()), "R9 masks",
        {rd_ok, wr_ok}, {e_rd(e_lvl()), e_wr(e_lvl())});
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1;
    if (a >= 8'h7B && a <= 8'h7E) m_entry[(3-(a-8'h7B))*8 +: 8] = d;
    else if (a >= 8'hD3 && a <= 8'hD6 && e_lvl() == 2) m_pw1[(3-(a-8'hD3))*8 +: 8] = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [7:0] a, string req);
    @(negedge clk);
    addr = a; re = 1;
    #1;
    chk(rdata == e_read(a), req, rdata, e_read(a));
    re = 0;
  endtask

  task automatic wr32(logic [7:0] base, logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(base + 8'(i), v[(3-i)*8 +: 8]);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    m_entry = '1; m_pw1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_lvl("R1 reset level");
    chk(lvl1 == 2'd1, "R10 all-ones level 1 password", lvl1, 1);
    rd(8'h7B, "R7 entry read");
    rd(8'hD3, "R8 locked pw1 read");
    wr(8'hD3, 8'hAA);
    check_lvl("R6 locked write");
    wr32(8'h7B, 32'h0);
    check_lvl("R4 double match level 2");
    chk(lvl == 2'd2, "R4 level 2 wins", lvl, 2);
    rd(8'h7D, "R7 entry read at level 2");
    wr32(8'hD3, 32'h1234_5678);
    rd(8'hD4, "R8 pw1 readback");
    rd(8'h10, "R8 unowned read");
    wr(8'h7E, 8'h00);
    chk(lvl == 2'd2, "R5 same value rewrite", lvl, 2);
    wr32(8'h7B, 32'h1234_5678);
    check_lvl("R3 level 1 grant");
    chk(lvl == 2'd1, "R3 level 1", lvl, 1);
    rd(8'hD3, "R8 pw1 hidden at level 1");
    wr(8'hD6, 8'h00);
    chk(lvl == 2'd1, "R6 write ignored at level 1", lvl, 1);
    wr32(8'h7B, 32'h1234_5678);
    check_lvl("R6 pw1 unchanged");
    wr(8'h7C, 8'h35);
    check_lvl("R2 byte mismatch drops access");
    chk(lvl == 2'd0, "R2 dropped", lvl, 0);
    wr(8'h7C, 8'h34);
    chk(lvl == 2'd1, "R2 byte position", lvl, 1);
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, d;
      int k;
      k = $urandom % 3;
      a = k == 0 ? 8'h7B + 8'($urandom % 4) : k == 1 ? 8'hD3 + 8'($urandom % 4) : 8'($urandom);
      k = $urandom % 3;
      d = k == 0 ? 8'h00 : k == 1 ? m_pw1[($urandom % 4)*8 +: 8] : 8'($urandom);
      if ($urandom % 4 == 0) rd(a, "R8 random read");
      else begin wr(a, d); check_lvl("R5 random write"); end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule